// File: doc/BRIEF.md
# IQ Imbalance Corrector

This block removes a fixed gain and phase mismatch between the in-phase and quadrature rails of a complex sample stream. Each accepted sample is passed through a lower-triangular 2x2 matrix: the I rail is scaled by (1 + A/64), and a fraction B/64 of the I rail is added into the Q rail. The Q rail keeps unity gain. A and B are signed coefficients in units of 1/64. They are loaded through a small register-write port, with one address for each coefficient.

Samples arrive as signed I/Q words with a valid strobe and leave two clock cycles later, with the strobe delayed to match. Each scaled term is rounded to the nearest integer, and each result is clipped to the output word range. A run-time disable input sends samples through unchanged while keeping the same latency. A build-time parameter can remove the stage entirely, which leaves a zero-latency wire path.

Top module: `iq_balance_fix`

## Requirements
- R1: When the block is enabled, out_i = clip(I + round(I*A/64)), where A is the signed 18-bit gain coefficient.
- R2: When the block is enabled, out_q = clip(Q + round(I*B/64)), where B is the signed 18-bit skew coefficient. The Q input never mixes into I.
- R3: A write with cfg_wr high to address MAG_ADDR (default 0x10) loads A, and a write to PHS_ADDR (default 0x11) loads B. Writes to any other address, and cycles with cfg_wr low, leave both coefficients unchanged.
- R4: After reset both coefficients are zero, so the block is an identity transform. out_valid, out_i and out_q are zero while reset is held.
- R5: While bypass_all is high in the cycle a sample is accepted, that sample leaves unchanged (out_i = I, out_q = Q) with the normal latency.
- R6: Results are clipped to the range -2^(DW-1) .. 2^(DW-1)-1 (-32768..32767 at the default) and never wrap.
- R7: out_valid equals in_valid delayed by exactly two clock cycles. Output data on a valid cycle belongs to the sample accepted two cycles earlier.
- R8: A coefficient written in cycle t applies to samples accepted from cycle t+1 onward. A sample accepted in the same cycle as the write still uses the old value.
- R9: Rounding of each x/64 term is to the nearest integer, with ties toward positive infinity: floor((x+32)/64). For example, I=1 with A=32 gives 2, and I=-1 with A=32 gives -1.
- R10: With BYPASS_STAGE=1 the outputs equal the inputs in the same cycle, and the configuration port has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_wr | input | 1 | Coefficient write strobe |
| cfg_addr | input | AW (8) | Coefficient write address |
| cfg_data | input | CW (18) | Signed coefficient value |
| bypass_all | input | 1 | Run-time disable: pass samples unchanged |
| in_valid | input | 1 | Input sample strobe |
| in_i | input | DW (16) | Signed in-phase input |
| in_q | input | DW (16) | Signed quadrature input |
| out_valid | output | 1 | Output sample strobe |
| out_i | output | DW (16) | Corrected in-phase output |
| out_q | output | DW (16) | Corrected quadrature output |

## Verification
A coefficient register holding the wrong value shows up on the first valid output that leaves two cycles after the next accepted sample with nonzero I. A wrong A shows only on I and a wrong B shows only on Q, so the two rails separate the fault. A misaligned pipeline flag, such as a stale bypass bit or a late valid bit, changes the output within two cycles as a misplaced strobe or as data from the neighbouring sample. Errors in the rounding or clipping stage show only at exact half-LSB inputs and at full-scale inputs, so the stimulus aims at those values directly.

// File: rtl/iq_bal_pkg.sv
// Package: iq_bal_pkg
// Shared definitions for the IQ imbalance corrector.
// Assumes the coefficient scaling is a power of two expressed as a shift.
package iq_bal_pkg;
    // Number of fraction bits in the coefficients (1/64 units)
    localparam int FRAC_BITS = 6;

    // Which coefficient register a configuration write selects
    typedef enum logic [1:0] {
        SEL_NONE = 2'd0,
        SEL_MAG  = 2'd1,
        SEL_PHS  = 2'd2
    } coef_sel_e;
endpackage

// File: rtl/iq_bal_coef_regs.sv
// Module: iq_bal_coef_regs
// Holds the gain (A) and skew (B) coefficients, which the write port loads.
// Assumes the two addresses differ. Both registers reset to zero (identity).
module iq_bal_coef_regs
    import iq_bal_pkg::*;
#(
    parameter int AW       = 8,
    parameter int CW       = 18,
    parameter int MAG_ADDR = 16,
    parameter int PHS_ADDR = 17
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr,
    input  logic [AW-1:0]        addr,
    input  logic signed [CW-1:0] data,
    output logic signed [CW-1:0] mag,
    output logic signed [CW-1:0] phs
);
    localparam logic [AW-1:0] MAG_A = AW'(MAG_ADDR);
    localparam logic [AW-1:0] PHS_A = AW'(PHS_ADDR);

    coef_sel_e sel;

    // Decode the write address into a register select
    always_comb begin
        sel = SEL_NONE;
        if (wr && addr == MAG_A)      sel = SEL_MAG;
        else if (wr && addr == PHS_A) sel = SEL_PHS;
    end

    // Load the selected coefficient; clear both on reset
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mag <= '0;
            phs <= '0;
        end else begin
            if (sel == SEL_MAG) mag <= data;
            if (sel == SEL_PHS) phs <= data;
        end
    end
endmodule

// File: rtl/iq_bal_mult_stage.sv
// Module: iq_bal_mult_stage
// First pipeline stage. It registers the sample, its valid and bypass flags,
// and the two full-precision products I*A and I*B.
// Assumes PW >= DW + CW, so the products cannot overflow.
module iq_bal_mult_stage #(
    parameter int DW = 16,
    parameter int CW = 18,
    parameter int PW = DW + CW
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 in_valid,
    input  logic                 in_byp,
    input  logic signed [DW-1:0] in_i,
    input  logic signed [DW-1:0] in_q,
    input  logic signed [CW-1:0] mag,
    input  logic signed [CW-1:0] phs,
    output logic                 s1_valid,
    output logic                 s1_byp,
    output logic signed [DW-1:0] s1_i,
    output logic signed [DW-1:0] s1_q,
    output logic signed [PW-1:0] s1_pa,
    output logic signed [PW-1:0] s1_pb
);
    logic signed [PW-1:0] pa_c;
    logic signed [PW-1:0] pb_c;

    // Full-precision signed products with the current coefficients
    always_comb begin
        pa_c = PW'(in_i) * PW'(mag);
        pb_c = PW'(in_i) * PW'(phs);
    end

    // Register the sample, its flags and the products
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1_valid <= 1'b0;
            s1_byp   <= 1'b0;
            s1_i     <= '0;
            s1_q     <= '0;
            s1_pa    <= '0;
            s1_pb    <= '0;
        end else begin
            s1_valid <= in_valid;
            s1_byp   <= in_byp;
            s1_i     <= in_i;
            s1_q     <= in_q;
            s1_pa    <= pa_c;
            s1_pb    <= pb_c;
        end
    end
endmodule

// File: rtl/iq_bal_rail.sv
// Module: iq_bal_rail
// Combinational rail arithmetic: y = clip(base + round(prod / 2^FRAC)).
// Rounds to nearest with ties toward +inf, and clips to the DW-bit range.
// Assumes FRAC >= 1.
module iq_bal_rail #(
    parameter int DW   = 16,
    parameter int PW   = 34,
    parameter int FRAC = 6
) (
    input  logic signed [DW-1:0] base,
    input  logic signed [PW-1:0] prod,
    output logic signed [DW-1:0] y
);
    localparam int SW = PW + 2;
    localparam logic signed [SW-1:0] HALF = SW'(64'sd1 <<< (FRAC - 1));
    localparam logic signed [SW-1:0] MAXV = SW'((64'sd1 <<< (DW - 1)) - 64'sd1);
    localparam logic signed [SW-1:0] MINV = SW'(-(64'sd1 <<< (DW - 1)));

    logic signed [SW-1:0] prod_x;
    logic signed [SW-1:0] rnd;
    logic signed [SW-1:0] sum;

    // Round the scaled term, add the base and clip to the output range
    always_comb begin
        prod_x = {{2{prod[PW-1]}}, prod};
        rnd    = (prod_x + HALF) >>> FRAC;
        sum    = rnd + {{(SW-DW){base[DW-1]}}, base};
        if (sum > MAXV)      y = MAXV[DW-1:0];
        else if (sum < MINV) y = MINV[DW-1:0];
        else                 y = sum[DW-1:0];
    end
endmodule

// File: rtl/iq_balance_fix.sv
// Module: iq_balance_fix
// IQ imbalance corrector: I' = I*(1 + A/64), Q' = Q + I*B/64.
// The latency is two cycles. bypass_all passes samples unchanged with the same
// latency. BYPASS_STAGE=1 removes the logic and leaves a zero-latency wire.
// Assumes DW <= 30 and CW <= 30, so intermediate widths fit in 64 bits.
module iq_balance_fix
    import iq_bal_pkg::*;
#(
    parameter int DW           = 16,
    parameter int CW           = 18,
    parameter int AW           = 8,
    parameter int MAG_ADDR     = 16,
    parameter int PHS_ADDR     = 17,
    parameter bit BYPASS_STAGE = 1'b0
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cfg_wr,
    input  logic [AW-1:0]        cfg_addr,
    input  logic signed [CW-1:0] cfg_data,
    input  logic                 bypass_all,
    input  logic                 in_valid,
    input  logic signed [DW-1:0] in_i,
    input  logic signed [DW-1:0] in_q,
    output logic                 out_valid,
    output logic signed [DW-1:0] out_i,
    output logic signed [DW-1:0] out_q
);
    localparam int PW = DW + CW;

    logic signed [CW-1:0] mag_q;
    logic signed [CW-1:0] phs_q;

    generate
        if (BYPASS_STAGE) begin : g_wire
            // Stage removed: straight-through path
            assign mag_q     = '0;
            assign phs_q     = '0;
            assign out_valid = in_valid;
            assign out_i     = in_i;
            assign out_q     = in_q;
        end else begin : g_core
            logic                 s1_valid;
            logic                 s1_byp;
            logic signed [DW-1:0] s1_i;
            logic signed [DW-1:0] s1_q;
            logic signed [PW-1:0] s1_pa;
            logic signed [PW-1:0] s1_pb;
            logic signed [DW-1:0] cor_i;
            logic signed [DW-1:0] cor_q;

            iq_bal_coef_regs #(
                .AW(AW), .CW(CW), .MAG_ADDR(MAG_ADDR), .PHS_ADDR(PHS_ADDR)
            ) u_coef (
                .clk(clk), .rst_n(rst_n), .wr(cfg_wr), .addr(cfg_addr),
                .data(cfg_data), .mag(mag_q), .phs(phs_q)
            );

            iq_bal_mult_stage #(.DW(DW), .CW(CW), .PW(PW)) u_mult (
                .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_byp(bypass_all),
                .in_i(in_i), .in_q(in_q), .mag(mag_q), .phs(phs_q),
                .s1_valid(s1_valid), .s1_byp(s1_byp), .s1_i(s1_i), .s1_q(s1_q),
                .s1_pa(s1_pa), .s1_pb(s1_pb)
            );

            iq_bal_rail #(.DW(DW), .PW(PW), .FRAC(FRAC_BITS)) u_rail_i (
                .base(s1_i), .prod(s1_pa), .y(cor_i)
            );

            iq_bal_rail #(.DW(DW), .PW(PW), .FRAC(FRAC_BITS)) u_rail_q (
                .base(s1_q), .prod(s1_pb), .y(cor_q)
            );

            // Output register: choose the corrected or the untouched sample
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    out_valid <= 1'b0;
                    out_i     <= '0;
                    out_q     <= '0;
                end else begin
                    out_valid <= s1_valid;
                    out_i     <= s1_byp ? s1_i : cor_i;
                    out_q     <= s1_byp ? s1_q : cor_q;
                end
            end
        end
    endgenerate
endmodule

// File: rtl/iq_bal_checker.sv
// Module: iq_bal_checker
// Property checker bound to iq_balance_fix. It checks the coefficient
// loading, the latency, the bypass behaviour and the identity transform.
// Assumes it sees the top's coefficient registers through the bind.
module iq_bal_checker #(
    parameter int DW           = 16,
    parameter int CW           = 18,
    parameter int AW           = 8,
    parameter int MAG_ADDR     = 16,
    parameter int PHS_ADDR     = 17,
    parameter bit BYPASS_STAGE = 1'b0
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 cfg_wr,
    input logic [AW-1:0]        cfg_addr,
    input logic signed [CW-1:0] cfg_data,
    input logic                 bypass_all,
    input logic                 in_valid,
    input logic signed [DW-1:0] in_i,
    input logic signed [DW-1:0] in_q,
    input logic                 out_valid,
    input logic signed [DW-1:0] out_i,
    input logic signed [DW-1:0] out_q,
    input logic signed [CW-1:0] mag,
    input logic signed [CW-1:0] phs
);
    generate
        if (!BYPASS_STAGE) begin : g_props
            p_mag_load_r3: assert property (@(posedge clk) disable iff (!rst_n)
                (cfg_wr && cfg_addr == AW'(MAG_ADDR)) |=> (mag == $past(cfg_data)));

            p_phs_load_r3: assert property (@(posedge clk) disable iff (!rst_n)
                (cfg_wr && cfg_addr == AW'(PHS_ADDR)) |=> (phs == $past(cfg_data)));

            p_coef_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
                !cfg_wr |=> ($stable(mag) && $stable(phs)));

            p_valid_on_r7: assert property (@(posedge clk) disable iff (!rst_n)
                in_valid |=> ##1 out_valid);

            p_valid_off_r7: assert property (@(posedge clk) disable iff (!rst_n)
                !in_valid |=> ##1 !out_valid);

            p_bypass_pass_r5: assert property (@(posedge clk) disable iff (!rst_n)
                (in_valid && bypass_all) |=> ##1
                    (out_i == $past(in_i, 2) && out_q == $past(in_q, 2)));

            p_identity_r4: assert property (@(posedge clk) disable iff (!rst_n)
                (in_valid && mag == '0 && phs == '0) |=> ##1
                    (out_i == $past(in_i, 2) && out_q == $past(in_q, 2)));
        end else begin : g_wire_props
            p_wire_r10: assert property (@(posedge clk) disable iff (!rst_n)
                (out_valid == in_valid) && (out_i == in_i) && (out_q == in_q));
        end
    endgenerate
endmodule

bind iq_balance_fix iq_bal_checker #(
    .DW(DW), .CW(CW), .AW(AW), .MAG_ADDR(MAG_ADDR), .PHS_ADDR(PHS_ADDR),
    .BYPASS_STAGE(BYPASS_STAGE)
) u_iq_bal_chk (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_addr(cfg_addr),
    .cfg_data(cfg_data), .bypass_all(bypass_all), .in_valid(in_valid),
    .in_i(in_i), .in_q(in_q), .out_valid(out_valid), .out_i(out_i),
    .out_q(out_q), .mag(mag_q), .phs(phs_q)
);

// File: tb/iq_balance_fix_bench.sv
// Bench for iq_balance_fix. A behavioural reference model (an expected-value
// queue) is compared with the outputs on every clock. A second instance
// built with BYPASS_STAGE=1 is checked for a same-cycle pass-through.
module iq_balance_fix_bench;
    localparam int DW = 16;
    localparam int CW = 18;
    localparam int AW = 8;
    localparam longint MAXV = 32767;
    localparam longint MINV = -32768;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cfg_wr = 1'b0;
    logic [AW-1:0] cfg_addr = '0;
    logic signed [CW-1:0] cfg_data = '0;
    logic bypass_all = 1'b0;
    logic in_valid = 1'b0;
    logic signed [DW-1:0] in_i = '0;
    logic signed [DW-1:0] in_q = '0;
    logic out_valid, w_valid;
    logic signed [DW-1:0] out_i, out_q, w_i, w_q;

    int errors = 0;
    int checks = 0;
    string tag = "R4";
    bit done = 1'b0;

    always #2 clk = ~clk;

    iq_balance_fix u_iq_balance_fix (
        .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_addr(cfg_addr),
        .cfg_data(cfg_data), .bypass_all(bypass_all), .in_valid(in_valid),
        .in_i(in_i), .in_q(in_q), .out_valid(out_valid), .out_i(out_i), .out_q(out_q)
    );

    iq_balance_fix #(.BYPASS_STAGE(1'b1)) u_iq_balance_fix_wire (
        .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_addr(cfg_addr),
        .cfg_data(cfg_data), .bypass_all(bypass_all), .in_valid(in_valid),
        .in_i(in_i), .in_q(in_q), .out_valid(w_valid), .out_i(w_i), .out_q(w_q)
    );

    typedef struct { bit v; longint i; longint q; } exp_t;
    exp_t eq[$];
    longint m_a = 0;
    longint m_b = 0;

    function automatic longint clip(longint x);
        if (x > MAXV) return MAXV;
        if (x < MINV) return MINV;
        return x;
    endfunction

    // round(x/64): floor((x+32)/64), with floor written out for negatives
    function automatic longint rnd64(longint x);
        longint n;
        n = x + 32;
        if (n >= 0) return n / 64;
        return -((-n + 63) / 64);
    endfunction

    task automatic check(bit ok, string req, longint act, longint exp_v, string what);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp_v);
        end
    endtask

    // Reference model: one entry per clock, two-deep delay
    always @(posedge clk) begin
        if (!rst_n) begin
            eq.delete();
            m_a = 0;
            m_b = 0;
        end else begin
            exp_t e;
            longint xi, xq;
            xi = longint'(in_i);
            xq = longint'(in_q);
            e.v = in_valid;
            if (bypass_all) begin
                e.i = xi;
                e.q = xq;
            end else begin
                e.i = clip(xi + rnd64(xi * m_a));
                e.q = clip(xq + rnd64(xi * m_b));
            end
            eq.push_back(e);
            if (eq.size() > 2) void'(eq.pop_front());
            if (cfg_wr && cfg_addr == 8'h10) m_a = longint'(cfg_data);
            if (cfg_wr && cfg_addr == 8'h11) m_b = longint'(cfg_data);
        end
    end

    // Compare on every clock, away from the active edge
    always @(negedge clk) begin
        if (!done) begin
            if (!rst_n) begin
                check(out_valid == 1'b0, "R4", longint'(out_valid), 0, "out_valid in reset");
                check(out_i == '0 && out_q == '0, "R4", longint'(out_i), 0, "data in reset");
            end else begin
                exp_t e;
                if (eq.size() == 2) e = eq[0];
                else begin e.v = 0; e.i = 0; e.q = 0; end
                check(out_valid == e.v, "R7", longint'(out_valid), longint'(e.v), "out_valid");
                if (e.v) begin
                    check(longint'(out_i) == e.i, tag, longint'(out_i), e.i, "out_i R1");
                    check(longint'(out_q) == e.q, tag, longint'(out_q), e.q, "out_q R2");
                end
            end
            // R10: wire build follows inputs in the same cycle
            check(w_valid == in_valid && w_i == in_i && w_q == in_q, "R10",
                  longint'(w_i), longint'(in_i), "wire path");
        end
    end

    task automatic send(int i, int q);
        @(negedge clk);
        cfg_wr = 1'b0;
        in_valid = 1'b1;
        in_i = DW'(i);
        in_q = DW'(q);
    endtask

    task automatic idle(int n);
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            cfg_wr = 1'b0;
            in_valid = 1'b0;
        end
    endtask

    task automatic wr(int addr, int val);
        @(negedge clk);
        in_valid = 1'b0;
        cfg_wr = 1'b1;
        cfg_addr = AW'(addr);
        cfg_data = CW'(val);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        tag = "R4";
        send(100, -200); send(32767, -32768); send(-1, 1); send(0, 5);
        idle(3);
        tag = "R3";
        wr(16, 64); idle(1);
        send(100, 7); send(-100, -7); send(1234, 0);
        wr(17, -32);
        send(640, 10); send(-640, -10);
        wr(18, 5);
        @(negedge clk); cfg_wr = 1'b0; cfg_addr = 8'h10; cfg_data = CW'(7);
        send(300, 300); send(-300, 1);
        idle(3);
        tag = "R8";
        @(negedge clk);
        cfg_wr = 1'b1; cfg_addr = 8'h10; cfg_data = CW'(0);
        in_valid = 1'b1; in_i = DW'(500); in_q = DW'(0);
        send(500, 0);
        idle(3);
        tag = "R1";
        wr(16, -20); wr(17, 13);
        send(1000, 50); send(-777, -333); send(12345, 2); send(-32768, 100);
        idle(3);
        tag = "R9";
        wr(16, 32); wr(17, -32);
        send(1, 0); send(-1, 0); send(3, 4); send(-3, -4); send(5, 1);
        idle(3);
        tag = "R6";
        wr(16, 64); wr(17, 64);
        send(30000, 0); send(-30000, -30000); send(32767, 32767); send(-32768, -32768);
        idle(3);
        tag = "R5";
        bypass_all = 1'b1;
        send(30000, 123); send(-456, 789);
        bypass_all = 1'b0;
        send(200, 0);
        idle(3);
        tag = "R7";
        send(10, 1); idle(1); send(20, 2); send(30, 3); idle(2); send(-40, 4);
        idle(4);
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            errors++;
            checks++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule